// File: doc/BRIEF.md
# Four-Channel Output Command Serial Port

This block is the serial control port of a four-channel low-side output driver. A host selects it by pulling an active-low select line, clocks in a command word of 8 or 16 bits with the most significant bit first, and releases the select line. On that release the last four bits received become the channel command register. Each channel's effective on command is its register bit ORed with a parallel input pin. The parallel pins let a host apply pulse-width modulation to a channel without serial traffic.

While the host writes, the port returns the latched fault status of the four channels on its serial data output. The status byte is loaded when select falls. After eight clocks the output carries the bits that were shifted in, so several devices can share one chain. When select is released the port sends a one-cycle clear pulse to the protection logic, which holds the fault latches.

The serial pins are oversampled by the system clock through synchronizers. The serial output is presented as a data bit together with an output enable, and the pad ring turns the enable into the high-impedance state.

Top module: `chan_cmd_spi`

## Requirements
- R1: During and after reset, and before any transfer, `chanOn` equals `pwmIn`, `faultClr` is 0 and `spiMisoOe` is 0. The synchronizers reset with select high, clock low and data low.
- R2: Data is sampled on rising serial clock edges, most significant bit first. On the rise of `spiCsN`, channel n takes the bit received n+1 positions from the end: the last bit goes to channel 0 and the fourth from last goes to channel 3.
- R3: Words of 8 and 16 bits both update the command register from their final four bits only.
- R4: `spiMisoOe` is 1 while the synchronized select is low and 0 while it is high.
- R5: When select falls, the readback byte {0000, faultIn[3:0]} is loaded. Its bit 7 is on `spiMiso` before the first clock, and each falling clock edge moves on to the next lower bit. Bit n is the fault of channel n, where 1 means faulted.
- R6: After eight falling clock edges in one selection, `spiMiso` carries the received bits in arrival order. In a 16-bit transfer the first byte written reappears during the second byte.
- R7: `chanOn[n]` equals command bit n OR `pwmIn[n]`.
- R8: `faultClr` is high for exactly one clock cycle after each rise of select, and at no other time.
- R9: Serial clock edges that occur while select is high change neither the command register nor the data that the next selection reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSclk | input | 1 | Serial clock from host |
| spiCsN | input | 1 | Active-low select from host |
| spiMosi | input | 1 | Serial data in |
| spiMiso | output | 1 | Serial data out (valid when enabled) |
| spiMisoOe | output | 1 | Output enable for the serial data pad |
| pwmIn | input | 4 | Parallel per-channel on inputs |
| faultIn | input | 4 | Latched fault flags from protection logic |
| chanOn | output | 4 | Effective per-channel on commands |
| faultClr | output | 1 | One-cycle fault latch clear pulse |

## Verification
The bench writes an 8-bit word and a 16-bit word with different final nibbles. A design that kept the first four bits, or a fixed bit position, would latch the wrong channels. A scoreboard compares every readback bit at the host's sampling edge, including the second byte of a long word, which catches a readback that is loaded late, reversed, or missing its forwarding path. Serial clock toggles while the device is deselected, followed by an empty selection, expose a shifter that runs without select. Counting clear pulses and the cycles they last shows a pulse that is missing, doubled or stretched.

// File: rtl/chan_cmd_spi_pkg.sv
package chan_cmd_spi_pkg;
  // strobes from the serial control to the datapath, one system cycle each
  typedef struct packed {
    logic selected;
    logic csFall;
    logic csRise;
    logic sclkRise;
    logic sclkFall;
  } strobe_t;
endpackage

// File: rtl/chan_cmd_spi_ctrl.sv
module chan_cmd_spi_ctrl
  import chan_cmd_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkPin,
  input  logic    csNPin,
  input  logic    mosiPin,
  output strobe_t strb,
  output logic    mosiBit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclkPipe, csPipe, mosiPipe;
  logic sclkPrev, csPrev;

  // select resets high (deselected), clock and data low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[LAST-1:0], sclkPin};
      csPipe   <= {csPipe[LAST-1:0], csNPin};
      mosiPipe <= {mosiPipe[LAST-1:0], mosiPin};
      sclkPrev <= sclkPipe[LAST];
      csPrev   <= csPipe[LAST];
    end
  end

  logic csNow, sclkNow;
  assign csNow   = csPipe[LAST];
  assign sclkNow = sclkPipe[LAST];
  assign mosiBit = mosiPipe[LAST];

  always_comb begin
    strb.selected = ~csNow;
    strb.csFall   = csPrev & ~csNow;
    strb.csRise   = ~csPrev & csNow;
    // clock edges count only while selected
    strb.sclkRise = ~csNow & ~sclkPrev & sclkNow;
    strb.sclkFall = ~csNow & sclkPrev & ~sclkNow;
  end
endmodule

// File: rtl/chan_cmd_spi_datapath.sv
module chan_cmd_spi_datapath
  import chan_cmd_spi_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int RB_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              mosiBit,
  input  logic [NUM_CH-1:0] faultIn,
  output logic [NUM_CH-1:0] cmdReg,
  output logic              misoBit,
  output logic              misoOe,
  output logic              faultClr
);
  localparam int PAD = RB_W - NUM_CH;

  logic [NUM_CH-1:0] lastBits;
  logic [RB_W-1:0]   outReg;
  logic              heldBit;

  // receive side: keep the most recent NUM_CH bits and the newest bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastBits <= '0;
      heldBit  <= 1'b0;
    end else if (strb.sclkRise) begin
      lastBits <= {lastBits[NUM_CH-2:0], mosiBit};
      heldBit  <= mosiBit;
    end
  end

  // transmit side: status load at select, then a chain shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (strb.csFall) begin
      outReg <= {{PAD{1'b0}}, faultIn};
    end else if (strb.sclkFall) begin
      outReg <= {outReg[RB_W-2:0], heldBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      faultClr <= 1'b0;
    end else begin
      faultClr <= strb.csRise;
      if (strb.csRise) cmdReg <= lastBits;
    end
  end

  assign misoBit = outReg[RB_W-1];
  assign misoOe  = strb.selected;
endmodule

// File: rtl/chan_cmd_spi.sv
module chan_cmd_spi
  import chan_cmd_spi_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int RB_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              spiMisoOe,
  input  logic [NUM_CH-1:0] pwmIn,
  input  logic [NUM_CH-1:0] faultIn,
  output logic [NUM_CH-1:0] chanOn,
  output logic              faultClr
);
  strobe_t           strb;
  logic              mosiBit;
  logic [NUM_CH-1:0] cmdReg;

  chan_cmd_spi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkPin(spiSclk), .csNPin(spiCsN),
    .mosiPin(spiMosi), .strb(strb), .mosiBit(mosiBit)
  );

  chan_cmd_spi_datapath #(.NUM_CH(NUM_CH), .RB_W(RB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiBit(mosiBit),
    .faultIn(faultIn), .cmdReg(cmdReg), .misoBit(spiMiso),
    .misoOe(spiMisoOe), .faultClr(faultClr)
  );

  // parallel inputs bypass the register for direct modulation
  assign chanOn = cmdReg | pwmIn;
endmodule

// File: rtl/chan_cmd_spi_checker.sv
module chan_cmd_spi_checker
  import chan_cmd_spi_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input strobe_t           strb,
  input logic [NUM_CH-1:0] cmdReg,
  input logic [NUM_CH-1:0] chanOn,
  input logic [NUM_CH-1:0] pwmIn,
  input logic              spiMiso,
  input logic              spiMisoOe,
  input logic              faultClr
);
  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.csRise |=> $stable(cmdReg));

  p_pwm_forces_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((pwmIn & ~chanOn) == '0));

  p_load_top_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.csFall |=> (!spiMiso && spiMisoOe));

  p_clr_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultClr |=> !faultClr);

  p_clr_after_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.csRise |=> faultClr);

  p_idle_no_shift_r9: assert property (@(posedge clk) disable iff (!rstN)
    !spiMisoOe |-> !(strb.sclkFall || strb.sclkRise));
endmodule

bind chan_cmd_spi chan_cmd_spi_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .cmdReg(cmdReg), .chanOn(chanOn),
  .pwmIn(pwmIn), .spiMiso(spiMiso), .spiMisoOe(spiMisoOe), .faultClr(faultClr)
);

// File: tb/chan_cmd_spi_test.sv
`timescale 1ns/1ps
module chan_cmd_spi_test;
  localparam int H = 10;  // system cycles per serial half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic [3:0] pwmIn = 4'h0, faultIn = 4'h0;
  logic spiMiso, spiMisoOe, faultClr;
  logic [3:0] chanOn;

  int checks = 0, fails = 0, clrCycles = 0;
  bit finished = 0;
  logic expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  chan_cmd_spi uut (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiMisoOe(spiMisoOe),
    .pwmIn(pwmIn), .faultIn(faultIn), .chanOn(chanOn), .faultClr(faultClr)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) if (faultClr) clrCycles++;

  // monitor: host samples the readback on each rising serial clock
  always @(posedge spiSclk) begin
    if (!spiCsN && expQ.size() > 0) begin
      logic e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(t, {15'b0, spiMiso}, {15'b0, e});
    end
  end

  // driver: pushes the expected readback, then clocks the word out
  task automatic xfer(logic [15:0] word, int nbits, logic [3:0] flt);
    logic [7:0] rb;
    faultIn = flt;
    rb = {4'b0000, flt};
    for (int i = 0; i < nbits; i++) begin
      if (i < 8) begin
        expQ.push_back(rb[7 - i]);
        tagQ.push_back("R5 readback bit");
      end else begin
        expQ.push_back(word[nbits - 1 - (i - 8)]);
        tagQ.push_back("R6 chained bit");
      end
    end
    waitClk(1);
    spiCsN = 1'b0;
    waitClk(H);
    chk("R4 oe while selected", {15'b0, spiMisoOe}, 16'h1);
    for (int i = 0; i < nbits; i++) begin
      spiMosi = word[nbits - 1 - i];
      waitClk(H);
      spiSclk = 1'b1;
      waitClk(H);
      spiSclk = 1'b0;
    end
    waitClk(H);
    spiCsN = 1'b1;
    spiMosi = 1'b0;
    waitClk(H);
    chk("R4 oe after deselect", {15'b0, spiMisoOe}, 16'h0);
    chk("R5 all readback consumed", 16'(expQ.size()), 16'h0);
  endtask

  initial begin
    waitClk(5);
    chk("R1 chanOn in reset", {12'b0, chanOn}, 16'h0);
    chk("R1 oe in reset", {15'b0, spiMisoOe}, 16'h0);
    rstN = 1'b1;
    waitClk(5);
    chk("R1 chanOn after reset", {12'b0, chanOn}, 16'h0);
    chk("R1 faultClr idle", {15'b0, faultClr}, 16'h0);
    chk("R1 oe idle", {15'b0, spiMisoOe}, 16'h0);

    // 8-bit word 0xA5: last four bits 0101
    xfer(16'h00A5, 8, 4'b0110);
    chk("R2 cmd from 8-bit word", {12'b0, chanOn}, 16'h0005);
    chk("R8 one clear cycle", 16'(clrCycles), 16'h1);

    // 16-bit word 0x12C3: last four bits 0011, first byte 0x12 chained
    xfer(16'h12C3, 16, 4'b1001);
    chk("R3 cmd from 16-bit word", {12'b0, chanOn}, 16'h0003);
    chk("R8 second clear cycle", 16'(clrCycles), 16'h2);

    // R7 parallel inputs OR into commands
    pwmIn = 4'b1000;
    waitClk(1);
    chk("R7 pwm ored", {12'b0, chanOn}, 16'h000B);
    pwmIn = 4'b0011;
    waitClk(1);
    chk("R7 pwm overlap", {12'b0, chanOn}, 16'h0003);
    pwmIn = 4'b0000;

    // R9 clock toggles while deselected must not shift
    spiMosi = 1'b1;
    for (int i = 0; i < 6; i++) begin
      waitClk(H); spiSclk = 1'b1; waitClk(H); spiSclk = 1'b0;
    end
    spiMosi = 1'b0;
    chk("R9 oe stays off", {15'b0, spiMisoOe}, 16'h0);
    xfer(16'h0000, 0, 4'b0000);
    chk("R9 cmd unchanged by idle clocks", {12'b0, chanOn}, 16'h0003);

    // 16-bit word with all ones at the end, byte 0xF0 chained
    xfer(16'hF00F, 16, 4'b1111);
    chk("R3 cmd all on", {12'b0, chanOn}, 16'h000F);
    chk("R8 clear count", 16'(clrCycles), 16'h4);

    // reset again returns channels off
    rstN = 1'b0;
    waitClk(3);
    chk("R1 chanOn after second reset", {12'b0, chanOn}, 16'h0);
    rstN = 1'b1;
    waitClk(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule